// File: doc/BRIEF.md
# Split-Bus Pipelining Arbiter

This block shares one system bus among several masters. The bus has separate address and data paths, and each path has its own tenures. Each master raises a request line. The arbiter gives the address bus to one master at a time with a one-cycle grant pulse. The master drives its address in the following cycle. In the cycle after that, the arbiter ends the address tenure with a one-cycle acknowledge. On that acknowledge, the owning master's index is written into a pending-tenure queue.

The data bus is granted separately. Whenever the data bus is idle and the queue holds an entry, the master at the head of the queue receives a data grant. The grant stays high until the data-complete input is sampled high. The entry is then removed. Because address tenures continue while data tenures are pending, the address bus can run ahead of the data bus. The queue holds `PIPE_DEPTH + 1` entries, and the arbiter stops granting the address bus while the queue is full, so the pipeline depth is bounded. Data tenures always follow the order of acknowledgement.

Top module: `pipeBusArb`

## Requirements
- R1: While `rstN` is low at a rising edge, and in the first cycle after it is released, every bit of `addrGnt` and `dataGnt` is low and `addrAck` is low.
- R2: An address grant is high for exactly one cycle. `addrAck` is high for exactly one cycle, two cycles after the grant cycle, and it belongs to that grant.
- R3: Address grants rotate round-robin. The search starts at the index after the last granted master, so after reset master 0 has the highest priority. A master that holds its request is not served twice while another master is waiting.
- R4: In any cycle at most one bit of `addrGnt` and at most one bit of `dataGnt` is high.
- R5: When the data bus is idle and the queue is empty, `dataGnt` for the acknowledged master goes high two cycles after its `addrAck` cycle. It stays unchanged until `dataDone` is sampled high.
- R6: Data grants are issued in the order in which their address tenures were acknowledged.
- R7: A new address tenure may be granted and acknowledged while an earlier data tenure is still in progress.
- R8: When `PIPE_DEPTH + 1` tenures are acknowledged and not yet completed, no address grant is issued. Granting resumes in the cycle after the completion that frees a slot.
- R9: `dataDone` sampled high while no data grant is active has no effect. It neither removes a queue entry nor causes a data grant.
- R10: After a completion, `dataGnt` is low for one cycle. The next queued master's data grant then appears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| busReq | input | NUM_MASTERS | Bus request, one bit per master |
| dataDone | input | 1 | Current data tenure completes when sampled high |
| addrGnt | output | NUM_MASTERS | Address bus grant pulse, one bit per master |
| dataGnt | output | NUM_MASTERS | Data bus grant, held for the whole data tenure |
| addrAck | output | 1 | One-cycle acknowledge ending the address tenure |

## Verification
The bench fills the queue to its limit while one master keeps requesting. A design that counted the queue wrongly would either issue that grant early or never release the address bus after a completion. It runs back-to-back address tenures against a held data tenure and then compares the order of data grants. A design that reordered data, or that refused to pipeline, would show the wrong owner or a missing address grant. Stray `dataDone` pulses on an idle data bus would corrupt a design without underflow protection. The corruption would show up as a missing or truncated data grant for the next master. Exact cycle checks on the grant-acknowledge-data sequence, and on the one-cycle gap after completion, catch any off-by-one in the sequencing.

// File: rtl/arbPkg.sv
package arbPkg;

  typedef enum logic [1:0] {
    AS_IDLE,
    AS_GRANT,
    AS_TENURE,
    AS_ACK
  } addrState_e;

  typedef struct packed {
    logic push;
    logic pop;
  } qStrobe_t;

endpackage

// File: rtl/arbQueue.sv
module arbQueue
  import arbPkg::*;
#(
  parameter int IDX_W = 2,
  parameter int DEPTH = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  qStrobe_t         strb,
  input  logic [IDX_W-1:0] pushIdx,
  output logic [IDX_W-1:0] headIdx,
  output logic             full,
  output logic             empty
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [IDX_W-1:0] slotMem [DEPTH];
  logic [PTR_W-1:0] wrPtr, rdPtr;
  logic [CNT_W-1:0] count;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST_PTR) ? '0 : p + PTR_W'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strb.push) wrPtr <= nextPtr(wrPtr);
      if (strb.pop)  rdPtr <= nextPtr(rdPtr);
      case ({strb.push, strb.pop})
        2'b10:   count <= count + CNT_W'(1);
        2'b01:   count <= count - CNT_W'(1);
        default: count <= count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (strb.push) slotMem[wrPtr] <= pushIdx;
  end

  assign headIdx = slotMem[rdPtr];
  assign full    = (count == FULL_CNT);
  assign empty   = (count == '0);

  // R8
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.push && !strb.pop) |-> !full);

  // R9
  no_underflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.pop |-> !empty);

endmodule

// File: rtl/arbCtrl.sv
module arbCtrl
  import arbPkg::*;
#(
  parameter int NUM   = 4,
  parameter int IDX_W = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [NUM-1:0]   busReq,
  input  logic             dataDone,
  input  logic             qFull,
  input  logic             qEmpty,
  input  logic [IDX_W-1:0] headIdx,
  output qStrobe_t         strb,
  output logic [IDX_W-1:0] pushIdx,
  output logic [NUM-1:0]   addrGnt,
  output logic [NUM-1:0]   dataGnt,
  output logic             addrAck
);

  localparam logic [NUM-1:0]   ONE_HOT0 = NUM'(1);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM - 1);

  addrState_e       aState;
  logic [IDX_W-1:0] owner;
  logic [IDX_W-1:0] lastIdx;
  logic [IDX_W-1:0] pick;
  logic             found;
  logic             dataBusy;

  // round-robin search starting after the last granted index
  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 1; k <= NUM; k++) begin
      int cand;
      cand = (int'(lastIdx) + k) % NUM;
      if (!found && busReq[cand]) begin
        found = 1'b1;
        pick  = IDX_W'(cand);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      aState  <= AS_IDLE;
      owner   <= '0;
      lastIdx <= LAST_IDX;
    end else begin
      case (aState)
        AS_IDLE: begin
          if (found && !qFull) begin
            aState  <= AS_GRANT;
            owner   <= pick;
            lastIdx <= pick;
          end
        end
        AS_GRANT:  aState <= AS_TENURE;
        AS_TENURE: aState <= AS_ACK;
        AS_ACK:    aState <= AS_IDLE;
        default:   aState <= AS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataBusy <= 1'b0;
    end else if (dataBusy && dataDone) begin
      dataBusy <= 1'b0;
    end else if (!dataBusy && !qEmpty) begin
      dataBusy <= 1'b1;
    end
  end

  assign strb.push = (aState == AS_ACK);
  assign strb.pop  = dataBusy && dataDone;
  assign pushIdx   = owner;
  assign addrAck   = (aState == AS_ACK);
  assign addrGnt   = (aState == AS_GRANT) ? (ONE_HOT0 << owner) : '0;
  assign dataGnt   = dataBusy ? (ONE_HOT0 << headIdx) : '0;

  // R4
  agnt_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(addrGnt));

  // R4
  dgnt_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(dataGnt));

  // R2
  ack_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    addrAck |=> !addrAck);

  // R2
  ack_after_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    addrAck |-> $past(|addrGnt, 2));

  // R5
  dgnt_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|dataGnt && !dataDone) |=> $stable(dataGnt));

  // R8
  full_blocks_grant_chk: assert property (@(posedge clk) disable iff (!rstN)
    qFull |=> !(|addrGnt));

endmodule

// File: rtl/pipeBusArb.sv
module pipeBusArb
  import arbPkg::*;
#(
  parameter int NUM_MASTERS = 4,
  parameter int PIPE_DEPTH  = 1
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [NUM_MASTERS-1:0] busReq,
  input  logic                   dataDone,
  output logic [NUM_MASTERS-1:0] addrGnt,
  output logic [NUM_MASTERS-1:0] dataGnt,
  output logic                   addrAck
);

  localparam int IDX_W   = (NUM_MASTERS > 1) ? $clog2(NUM_MASTERS) : 1;
  localparam int Q_DEPTH = PIPE_DEPTH + 1;

  qStrobe_t         strb;
  logic [IDX_W-1:0] pushIdx;
  logic [IDX_W-1:0] headIdx;
  logic             qFull;
  logic             qEmpty;

  arbCtrl #(
    .NUM   (NUM_MASTERS),
    .IDX_W (IDX_W)
  ) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .busReq   (busReq),
    .dataDone (dataDone),
    .qFull    (qFull),
    .qEmpty   (qEmpty),
    .headIdx  (headIdx),
    .strb     (strb),
    .pushIdx  (pushIdx),
    .addrGnt  (addrGnt),
    .dataGnt  (dataGnt),
    .addrAck  (addrAck)
  );

  arbQueue #(
    .IDX_W (IDX_W),
    .DEPTH (Q_DEPTH)
  ) i_queue (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .pushIdx (pushIdx),
    .headIdx (headIdx),
    .full    (qFull),
    .empty   (qEmpty)
  );

endmodule

// File: tb/test_pipeBusArb.sv
module test_pipeBusArb;

  localparam int N = 4;

  logic         clk = 1'b0;
  logic         rstN;
  logic [N-1:0] busReq;
  logic         dataDone;
  logic [N-1:0] addrGnt;
  logic [N-1:0] dataGnt;
  logic         addrAck;

  int nChecks = 0;
  int nFails  = 0;
  int agLog[64];
  int dgLog[64];
  int agN = 0;
  int dgN = 0;
  int multiGnt = 0;
  logic [N-1:0] prevDg = '0;
  bit   done = 0;

  always #5 clk = ~clk;

  pipeBusArb #(.NUM_MASTERS(N), .PIPE_DEPTH(1)) i_pipeBusArb (
    .clk      (clk),
    .rstN     (rstN),
    .busReq   (busReq),
    .dataDone (dataDone),
    .addrGnt  (addrGnt),
    .dataGnt  (dataGnt),
    .addrAck  (addrAck)
  );

  function automatic int ownerOf(input logic [N-1:0] v);
    for (int i = 0; i < N; i++) if (v[i]) return i;
    return -1;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // advance to the next falling edge, log grants, masters drop granted requests
  task automatic stepCycle();
    @(negedge clk);
    if ($countones(addrGnt) > 1 || $countones(dataGnt) > 1) multiGnt++;
    if (|addrGnt) begin
      if (agN < 64) agLog[agN] = ownerOf(addrGnt);
      agN++;
      busReq = busReq & ~addrGnt;
    end
    if (|dataGnt && dataGnt != prevDg) begin
      if (dgN < 64) dgLog[dgN] = ownerOf(dataGnt);
      dgN++;
    end
    prevDg = dataGnt;
  endtask

  task automatic testReset();
    rstN = 1'b0; busReq = '0; dataDone = 1'b0;
    repeat (3) stepCycle();
    check(addrGnt == 0 && dataGnt == 0 && !addrAck, "R1 in reset", int'(addrGnt | dataGnt), 0);
    rstN = 1'b1;
    stepCycle();
    check(addrGnt == 0 && dataGnt == 0 && !addrAck, "R1 after release", int'(addrGnt | dataGnt), 0);
  endtask

  task automatic testSingle();
    busReq[2] = 1'b1;
    stepCycle();
    check(addrGnt == 4'b0100, "R2 grant cycle", int'(addrGnt), 4);
    stepCycle();
    check(addrGnt == 0 && !addrAck, "R2 tenure cycle", int'(addrGnt), 0);
    stepCycle();
    check(addrAck == 1'b1, "R2 ack two cycles after grant", int'(addrAck), 1);
    stepCycle();
    check(!addrAck && dataGnt == 0, "R2 ack one cycle", int'(addrAck), 0);
    stepCycle();
    check(dataGnt == 4'b0100, "R5 data grant timing", int'(dataGnt), 4);
    repeat (3) stepCycle();
    check(dataGnt == 4'b0100, "R5 data grant held", int'(dataGnt), 4);
    dataDone = 1'b1;
    stepCycle();
    dataDone = 1'b0;
    check(dataGnt == 0, "R5 data grant released", int'(dataGnt), 0);
  endtask

  task automatic testRoundRobin();
    int base = agN;
    int dBase = dgN;
    dataDone = 1'b1;
    busReq = 4'b1011;
    for (int t = 0; t < 60 && agN < base + 3; t++) stepCycle();
    repeat (10) stepCycle();
    dataDone = 1'b0;
    check(agLog[base] == 3, "R3 first after master 2", agLog[base], 3);
    check(agLog[base+1] == 0, "R3 wraps to master 0", agLog[base+1], 0);
    check(agLog[base+2] == 1, "R3 then master 1", agLog[base+2], 1);
    check(dgN == dBase + 3 && dgLog[dBase] == 3 && dgLog[dBase+1] == 0 && dgLog[dBase+2] == 1,
          "R6 data order matches ack order", dgN - dBase, 3);
  endtask

  task automatic testPipeline();
    int base = agN;
    int dBase = dgN;
    bit blocked = 1'b1;
    busReq = 4'b1101;
    for (int t = 0; t < 60 && !addrGnt[3]; t++) stepCycle();
    // R7: second address tenure granted while first data tenure runs
    check(addrGnt == 4'b1000 && dataGnt == 4'b0100, "R7 address overlaps data",
          int'({addrGnt, dataGnt}), 8'b1000_0100);
    repeat (12) begin
      stepCycle();
      if (addrGnt != 0) blocked = 1'b0;
    end
    check(blocked, "R8 no grant while queue full", int'(blocked), 1);
    check(busReq[0] == 1'b1, "R8 master 0 still waiting", int'(busReq[0]), 1);
    check(dataGnt == 4'b0100, "R5 first data tenure held", int'(dataGnt), 4);
    dataDone = 1'b1;
    stepCycle();
    dataDone = 1'b0;
    check(dataGnt == 0, "R10 one idle cycle after completion", int'(dataGnt), 0);
    stepCycle();
    check(dataGnt == 4'b1000, "R10 next owner granted", int'(dataGnt), 8);
    check(addrGnt == 4'b0001, "R8 grant resumes after slot frees", int'(addrGnt), 1);
    dataDone = 1'b1;
    repeat (12) stepCycle();
    dataDone = 1'b0;
    check(agLog[base] == 2 && agLog[base+1] == 3 && agLog[base+2] == 0,
          "R3 rotation from master 1", agLog[base], 2);
    check(dgN == dBase + 3 && dgLog[dBase] == 2 && dgLog[dBase+1] == 3 && dgLog[dBase+2] == 0,
          "R6 pipelined data order", dgLog[dBase+2], 0);
  endtask

  task automatic testStrayDone();
    bit quiet = 1'b1;
    stepCycle();
    dataDone = 1'b1;
    repeat (4) begin
      stepCycle();
      if (dataGnt != 0) quiet = 1'b0;
    end
    dataDone = 1'b0;
    check(quiet, "R9 stray completion gives no grant", int'(quiet), 1);
    busReq[1] = 1'b1;
    repeat (5) stepCycle();
    check(dataGnt == 4'b0010, "R9 next tenure granted normally", int'(dataGnt), 2);
    repeat (3) stepCycle();
    check(dataGnt == 4'b0010, "R9 tenure not ended by stray pulse", int'(dataGnt), 2);
    dataDone = 1'b1;
    stepCycle();
    dataDone = 1'b0;
    check(dataGnt == 0, "R9 completion ends tenure", int'(dataGnt), 0);
  endtask

  initial begin
    testReset();
    testSingle();
    testRoundRobin();
    testPipeline();
    testStrayDone();
    check(multiGnt == 0, "R4 at most one grant per bus", multiGnt, 0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule